// File: doc/BRIEF.md
# Host Bus Register and Memory Window Decoder

This block is the slave end of a non-multiplexed asynchronous processor bus. The bus has 16 data bits and 8 address bits. It also has an active-low chip select, an active-low data strobe, a read/write line (high means read) and an active-low transfer acknowledge. The bus signals arrive unsynchronised. The chip-select and data-strobe lines pass through a synchroniser before a small phase sequencer accepts a transfer. The address, direction and write data are captured when the transfer is accepted.

The top address bit picks one of two address spaces. When it is low, the seven lower bits address a small set of internal registers directly. When it is high, the seven lower bits give a channel position inside a memory window. A control register chooses that window: its stream field selects the stream and its memory-select field selects the memory. The data memory window covers input streams and can only be read. The connection memory windows cover output streams and can be read and written. The memories are synchronous single-port RAMs outside the block. The block drives their enables, their shared address and their write data, and it takes back one read word per memory.

Top module: `hb_decoder`

## Requirements
- R1: After reset, bus_ack_n is 1, bus_rdata_oe is 0, blk_prog is 0, dev_mode is 0x0000, and the control and mode registers read back as 0x0000.
- R2: With bus_cs_n and bus_ds_n both driven low between clock edges, bus_ack_n goes low on rising edge SYNC_STAGES+3 after that point (edge 5 at default parameters). It goes low exactly once for each transfer.
- R3: After bus_ds_n is driven high between edges, bus_ack_n goes high on rising edge SYNC_STAGES+1 after that point (edge 3 at default parameters). While the strobe stays low, the acknowledge stays low.
- R4: Register 0x00 is the control register. Bits [4:0] are the stream, bits [7:5] the memory select and bit 8 the block-program flag. Bit 8 also drives blk_prog. Bits [15:9] read as 0. Register 0x01 is a 16-bit mode register that reads back in full and drives dev_mode.
- R5: A read of any register address from 0x03 to 0x7F (top address bit 0) returns 0x0000. A write there changes no other register.
- R6: With the top address bit 1 and memory select 0, a read issues one data memory read at address stream*128 + addr[6:0] and returns that word.
- R7: With the top address bit 1 and memory select k (1 to NUM_CMEM), reads and writes reach connection memory k-1 only, at address stream*128 + addr[6:0]. At most one write strobe is active in any cycle.
- R8: Writes to the data memory window and to register 0x02 are ignored: no memory write strobe fires and no stored value changes. They are still acknowledged with the normal timing.
- R9: Register 0x02 is read-only and returns the word delivered by the most recent data memory read.
- R10: A memory select above NUM_CMEM addresses nothing. Reads return 0x0000, and writes produce no strobe but are acknowledged.
- R11: bus_rdata_oe is 1 only while the acknowledge of a read is active, and 0 for writes and when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_cs_n | input | 1 | Chip select, active low, asynchronous |
| bus_ds_n | input | 1 | Data strobe, active low, asynchronous |
| bus_rw | input | 1 | 1 = read, 0 = write |
| bus_addr | input | 8 | Address; bit 7 selects the memory window |
| bus_wdata | input | 16 | Write data from the host |
| bus_rdata | output | 16 | Read data to the host |
| bus_rdata_oe | output | 1 | Read data drive enable |
| bus_ack_n | output | 1 | Transfer acknowledge, active low |
| blk_prog | output | 1 | Block-program flag from the control register |
| dev_mode | output | 16 | Mode register contents |
| dm_rd_en | output | 1 | Data memory read enable |
| dm_addr | output | 12 | Data memory address {stream, channel} |
| dm_rdata | input | 16 | Data memory read word, one cycle after enable |
| cm_we | output | NUM_CMEM | Connection memory write strobes |
| cm_re | output | NUM_CMEM | Connection memory read enables |
| cm_addr | output | 12 | Connection memory address {stream, channel} |
| cm_wdata | output | 16 | Connection memory write data |
| cm_rdata | input | 16*NUM_CMEM | Connection memory read words, memory k at bits [16k+15:16k] |

## Verification
The bench sweeps every register address, including all undefined ones, and every channel of several streams in each memory window. A decoder that aliased register addresses would return data where 0x0000 is due, and a wrong window address mapping would return data memory words that do not match the stream and channel. Connection memories are written one after the other and then read back together. A strobe that fired on the wrong memory would therefore overwrite the other memory's pattern. Writes to read-only places and to an unused memory select are checked against a count of write strobes. Every transfer also checks the acknowledge latency on both edges and the read drive enable, so a sequencer that skipped the fetch cycle or released on the wrong strobe would be caught.

// File: rtl/hb_pkg.sv
package hb_pkg;

  typedef enum logic [1:0] {PH_IDLE, PH_ISSUE, PH_FETCH, PH_ACK} phase_e;

  typedef enum logic [2:0] {
    TGT_CTRL, TGT_MODE, TGT_DREAD, TGT_NONE, TGT_DMEM, TGT_CMEM
  } tgt_e;

  localparam int REG_CTRL  = 0;
  localparam int REG_MODE  = 1;
  localparam int REG_DREAD = 2;

  // Map a captured address and the live memory select onto a target.
  function automatic tgt_e decode_target(input logic win, input int low,
                                         input int msel, input int ncm);
    tgt_e t;
    if (!win) begin
      case (low)
        REG_CTRL:  t = TGT_CTRL;
        REG_MODE:  t = TGT_MODE;
        REG_DREAD: t = TGT_DREAD;
        default:   t = TGT_NONE;
      endcase
    end else if (msel == 0) begin
      t = TGT_DMEM;
    end else if (msel <= ncm) begin
      t = TGT_CMEM;
    end else begin
      t = TGT_NONE;
    end
    return t;
  endfunction

  function automatic logic is_read_only(input tgt_e t);
    return (t == TGT_DMEM) || (t == TGT_DREAD);
  endfunction

endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '1;
    else        sh <= {sh[STAGES-2:0], din};
  end

  assign dout = sh[STAGES-1];
endmodule

// File: rtl/hb_handshake.sv
module hb_handshake
  import hb_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   sel_s,
  input  logic   ds_rel_s,
  output logic   start,
  output logic   issue,
  output logic   fetch,
  output logic   ack_n
);
  phase_e ph, ph_nx;

  always_comb begin
    ph_nx = ph;
    case (ph)
      PH_IDLE:  if (sel_s) ph_nx = PH_ISSUE;
      PH_ISSUE: ph_nx = PH_FETCH;
      PH_FETCH: ph_nx = PH_ACK;
      PH_ACK:   if (ds_rel_s) ph_nx = PH_IDLE;
      default:  ph_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph <= PH_IDLE;
    else        ph <= ph_nx;
  end

  assign start = (ph == PH_IDLE) && sel_s;
  assign issue = (ph == PH_ISSUE);
  assign fetch = (ph == PH_FETCH);
  assign ack_n = (ph != PH_ACK);
endmodule

// File: rtl/hb_regs.sv
module hb_regs
  import hb_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CTRL_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  tgt_e              tgt,
  input  logic [DATA_W-1:0] wdata,
  input  logic              dread_ld,
  input  logic [DATA_W-1:0] dread_val,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] mode_q,
  output logic [DATA_W-1:0] rd_val
);
  logic [DATA_W-1:0] dread_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      mode_q  <= '0;
      dread_q <= '0;
    end else begin
      if (wr_en && tgt == TGT_CTRL) ctrl_q <= wdata[CTRL_W-1:0];
      if (wr_en && tgt == TGT_MODE) mode_q <= wdata;
      if (dread_ld) dread_q <= dread_val;
    end
  end

  always_comb begin
    case (tgt)
      TGT_CTRL:  rd_val = DATA_W'(ctrl_q);
      TGT_MODE:  rd_val = mode_q;
      TGT_DREAD: rd_val = dread_q;
      default:   rd_val = '0;
    endcase
  end
endmodule

// File: rtl/hb_memwin.sv
module hb_memwin
  import hb_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int MEM_AW   = 12,
  parameter int MSEL_W   = 3,
  parameter int NUM_CMEM = 2
) (
  input  logic                       issue,
  input  logic                       rw,
  input  tgt_e                       tgt,
  input  logic [MSEL_W-1:0]          msel,
  input  logic [MEM_AW-1:0]          win_addr,
  input  logic [DATA_W-1:0]          wdata,
  output logic                       dm_rd_en,
  output logic [MEM_AW-1:0]          dm_addr,
  input  logic [DATA_W-1:0]          dm_rdata,
  output logic [NUM_CMEM-1:0]        cm_we,
  output logic [NUM_CMEM-1:0]        cm_re,
  output logic [MEM_AW-1:0]          cm_addr,
  output logic [DATA_W-1:0]          cm_wdata,
  input  logic [NUM_CMEM*DATA_W-1:0] cm_rdata,
  output logic [DATA_W-1:0]          win_rdata
);
  assign dm_rd_en = issue && rw && (tgt == TGT_DMEM);
  assign dm_addr  = win_addr;
  assign cm_addr  = win_addr;
  assign cm_wdata = wdata;

  for (genvar k = 0; k < NUM_CMEM; k++) begin : g_cm
    logic hit;
    assign hit      = (tgt == TGT_CMEM) && (int'(msel) == k + 1);
    assign cm_we[k] = issue && !rw && hit;
    assign cm_re[k] = issue && rw && hit;
  end

  always_comb begin
    win_rdata = '0;
    if (tgt == TGT_DMEM) win_rdata = dm_rdata;
    for (int k = 0; k < NUM_CMEM; k++) begin
      if (tgt == TGT_CMEM && int'(msel) == k + 1)
        win_rdata = cm_rdata[k*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/hb_decoder.sv
module hb_decoder
  import hb_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 16,
  parameter int STREAM_W    = 5,
  parameter int MSEL_W      = 3,
  parameter int NUM_CMEM    = 2,
  parameter int SYNC_STAGES = 2,
  localparam int CHAN_W     = ADDR_W - 1,
  localparam int MEM_AW     = STREAM_W + CHAN_W,
  localparam int CTRL_W     = STREAM_W + MSEL_W + 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_cs_n,
  input  logic                       bus_ds_n,
  input  logic                       bus_rw,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [DATA_W-1:0]          bus_wdata,
  output logic [DATA_W-1:0]          bus_rdata,
  output logic                       bus_rdata_oe,
  output logic                       bus_ack_n,
  output logic                       blk_prog,
  output logic [DATA_W-1:0]          dev_mode,
  output logic                       dm_rd_en,
  output logic [MEM_AW-1:0]          dm_addr,
  input  logic [DATA_W-1:0]          dm_rdata,
  output logic [NUM_CMEM-1:0]        cm_we,
  output logic [NUM_CMEM-1:0]        cm_re,
  output logic [MEM_AW-1:0]          cm_addr,
  output logic [DATA_W-1:0]          cm_wdata,
  input  logic [NUM_CMEM*DATA_W-1:0] cm_rdata
);
  // Named internal events, also watched by the bound checker.
  logic cs_s, ds_s, sel_s, ds_rel_s;
  logic start, issue, fetch;
  logic ro_write;

  logic [ADDR_W-1:0] addr_q;
  logic              rw_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;

  logic [CTRL_W-1:0]   ctrl_q;
  logic [STREAM_W-1:0] stream;
  logic [MSEL_W-1:0]   msel;
  tgt_e                tgt;
  logic [MEM_AW-1:0]   win_addr;
  logic [DATA_W-1:0]   reg_rd, win_rd;

  hb_sync #(.STAGES(SYNC_STAGES)) u_sync_cs (
    .clk(clk), .rst_n(rst_n), .din(bus_cs_n), .dout(cs_s));
  hb_sync #(.STAGES(SYNC_STAGES)) u_sync_ds (
    .clk(clk), .rst_n(rst_n), .din(bus_ds_n), .dout(ds_s));

  assign sel_s    = !cs_s && !ds_s;
  assign ds_rel_s = ds_s;

  hb_handshake u_hs (
    .clk(clk), .rst_n(rst_n), .sel_s(sel_s), .ds_rel_s(ds_rel_s),
    .start(start), .issue(issue), .fetch(fetch), .ack_n(bus_ack_n));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      rw_q    <= 1'b0;
      wdata_q <= '0;
    end else if (start) begin
      addr_q  <= bus_addr;
      rw_q    <= bus_rw;
      wdata_q <= bus_wdata;
    end
  end

  assign stream   = ctrl_q[STREAM_W-1:0];
  assign msel     = ctrl_q[STREAM_W +: MSEL_W];
  assign blk_prog = ctrl_q[CTRL_W-1];
  assign tgt      = decode_target(addr_q[ADDR_W-1], int'(addr_q[CHAN_W-1:0]),
                                  int'(msel), NUM_CMEM);
  assign win_addr = {stream, addr_q[CHAN_W-1:0]};
  assign ro_write = issue && !rw_q && is_read_only(tgt);

  hb_regs #(.DATA_W(DATA_W), .CTRL_W(CTRL_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(issue && !rw_q), .tgt(tgt), .wdata(wdata_q),
    .dread_ld(fetch && rw_q && tgt == TGT_DMEM), .dread_val(dm_rdata),
    .ctrl_q(ctrl_q), .mode_q(dev_mode), .rd_val(reg_rd));

  hb_memwin #(.DATA_W(DATA_W), .MEM_AW(MEM_AW), .MSEL_W(MSEL_W),
              .NUM_CMEM(NUM_CMEM)) u_win (
    .issue(issue), .rw(rw_q), .tgt(tgt), .msel(msel),
    .win_addr(win_addr), .wdata(wdata_q),
    .dm_rd_en(dm_rd_en), .dm_addr(dm_addr), .dm_rdata(dm_rdata),
    .cm_we(cm_we), .cm_re(cm_re), .cm_addr(cm_addr), .cm_wdata(cm_wdata),
    .cm_rdata(cm_rdata), .win_rdata(win_rd));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (fetch) rdata_q <= rw_q ? (reg_rd | win_rd) : '0;
  end

  assign bus_rdata    = rdata_q;
  assign bus_rdata_oe = !bus_ack_n && rw_q;
endmodule

// File: rtl/hb_decoder_chk.sv
module hb_decoder_chk #(
  parameter int NUM_CMEM = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                ack_n,
  input logic                rd_oe,
  input logic                issue,
  input logic                fetch,
  input logic                ds_rel_s,
  input logic                ro_write,
  input logic                dm_rd_en,
  input logic [NUM_CMEM-1:0] cm_we
);
  AST_WE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cm_we)); // R7
  AST_WE_IN_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    (|cm_we) |-> issue); // R7
  AST_RO_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    ro_write |-> (cm_we == '0)); // R8
  AST_DM_IN_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    dm_rd_en |-> issue); // R6
  AST_ACK_AFTER_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_n) |-> $past(fetch)); // R2
  AST_ACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_n && !ds_rel_s) |=> !ack_n); // R3
  AST_OE_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    rd_oe |-> !ack_n); // R11
endmodule

bind hb_decoder hb_decoder_chk #(.NUM_CMEM(NUM_CMEM)) u_chk (
  .clk(clk), .rst_n(rst_n), .ack_n(bus_ack_n), .rd_oe(bus_rdata_oe),
  .issue(issue), .fetch(fetch), .ds_rel_s(ds_rel_s), .ro_write(ro_write),
  .dm_rd_en(dm_rd_en), .cm_we(cm_we));

// File: tb/tb_hb_decoder.sv
module tb_hb_decoder;
  localparam int NCM  = 2;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n;
  logic        bus_cs_n, bus_ds_n, bus_rw;
  logic [7:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic        bus_rdata_oe, bus_ack_n, blk_prog;
  logic [15:0] dev_mode;
  logic        dm_rd_en;
  logic [11:0] dm_addr, cm_addr;
  logic [15:0] dm_rdata, cm_wdata;
  logic [NCM-1:0] cm_we, cm_re;
  logic [NCM*16-1:0] cm_rdata;

  hb_decoder #(.NUM_CMEM(NCM), .SYNC_STAGES(SYNC)) dut (
    .clk(clk), .rst_n(rst_n), .bus_cs_n(bus_cs_n), .bus_ds_n(bus_ds_n),
    .bus_rw(bus_rw), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rdata_oe(bus_rdata_oe), .bus_ack_n(bus_ack_n),
    .blk_prog(blk_prog), .dev_mode(dev_mode), .dm_rd_en(dm_rd_en),
    .dm_addr(dm_addr), .dm_rdata(dm_rdata), .cm_we(cm_we), .cm_re(cm_re),
    .cm_addr(cm_addr), .cm_wdata(cm_wdata), .cm_rdata(cm_rdata));

  function automatic logic [15:0] dm_word(input logic [11:0] a);
    logic [15:0] p;
    p = {4'h0, a} * 16'h9E37;
    return p ^ 16'h5A5A;
  endfunction

  function automatic logic [15:0] pat(input int m, input int s, input int c);
    return 16'((m * 977) ^ (s * 131) ^ (c * 2053) ^ 16'h8001);
  endfunction

  // Synchronous RAM models behind the block.
  logic [15:0] cmem [NCM][4096];
  int          wr_strobes = 0;
  logic [11:0] last_wr_addr = '0;
  always @(posedge clk) begin
    if (dm_rd_en) dm_rdata <= dm_word(dm_addr);
    for (int k = 0; k < NCM; k++) begin
      if (cm_we[k]) begin
        cmem[k][cm_addr] <= cm_wdata;
        wr_strobes++;
        last_wr_addr = cm_addr;
      end
      if (cm_re[k]) cm_rdata[k*16 +: 16] <= cmem[k][cm_addr];
    end
  end

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(input logic rd, input logic [7:0] a, input logic [15:0] wd,
                        output logic [15:0] rdv);
    int lat, rel;
    @(negedge clk);
    bus_addr = a; bus_rw = rd; bus_wdata = wd;
    bus_cs_n = 1'b0; bus_ds_n = 1'b0;
    lat = 0;
    do begin @(negedge clk); lat++; end while (bus_ack_n && lat < 20);
    check("R2 ack latency", lat, SYNC + 3);
    rdv = bus_rdata;
    check("R11 oe during ack", {31'd0, bus_rdata_oe}, {31'd0, rd});
    bus_ds_n = 1'b1; bus_cs_n = 1'b1;
    rel = 0;
    do begin @(negedge clk); rel++; end while (!bus_ack_n && rel < 20);
    check("R3 ack release", rel, SYNC + 1);
    check("R11 oe idle", {31'd0, bus_rdata_oe}, 32'd0);
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    logic [15:0] dummy;
    access(1'b0, a, d, dummy);
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [15:0] exp);
    logic [15:0] v;
    access(1'b1, a, 16'h0, v);
    check(req, {16'd0, v}, {16'd0, exp});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int strm[3];
    int ws;
    rst_n = 1'b0; bus_cs_n = 1'b1; bus_ds_n = 1'b1; bus_rw = 1'b1;
    bus_addr = '0; bus_wdata = '0; cm_rdata = '0; dm_rdata = '0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check("R1 ack idle", {31'd0, bus_ack_n}, 32'd1);
    check("R1 oe idle", {31'd0, bus_rdata_oe}, 32'd0);
    check("R1 blk_prog", {31'd0, blk_prog}, 32'd0);
    check("R1 dev_mode", {16'd0, dev_mode}, 32'd0);
    rst_n = 1'b1;
    rd_chk("R1 ctrl reset", 8'h00, 16'h0000);
    rd_chk("R1 mode reset", 8'h01, 16'h0000);

    // R4 control and mode registers
    wr(8'h00, 16'hFFFF);
    rd_chk("R4 ctrl mask", 8'h00, 16'h01FF);
    check("R4 blk_prog out", {31'd0, blk_prog}, 32'd1);
    wr(8'h01, 16'hA55A);
    rd_chk("R4 mode", 8'h01, 16'hA55A);
    wr(8'h01, 16'h1234);
    rd_chk("R4 mode 2", 8'h01, 16'h1234);
    check("R4 dev_mode out", {16'd0, dev_mode}, 32'h1234);

    // R5 undefined register space sweep
    for (int a = 3; a < 128; a++) begin
      wr(8'(a), 16'hBEEF ^ 16'(a));
      rd_chk("R5 undefined reg", 8'(a), 16'h0000);
    end
    rd_chk("R5 ctrl intact", 8'h00, 16'h01FF);
    rd_chk("R5 mode intact", 8'h01, 16'h1234);

    // R7 connection memory sweep: write both memories, then read back
    strm[0] = 0; strm[1] = 5; strm[2] = 31;
    for (int m = 1; m <= NCM; m++) begin
      for (int si = 0; si < 3; si++) begin
        wr(8'h00, 16'((m << 5) | strm[si]));
        for (int c = 0; c < 128; c++) begin
          wr(8'h80 | 8'(c), pat(m, strm[si], c));
          check("R7 write address", {20'd0, last_wr_addr}, 32'(strm[si] * 128 + c));
        end
      end
    end
    for (int m = 1; m <= NCM; m++) begin
      for (int si = 0; si < 3; si++) begin
        wr(8'h00, 16'((m << 5) | strm[si]));
        for (int c = 0; c < 128; c++)
          rd_chk("R7 cmem readback", 8'h80 | 8'(c), pat(m, strm[si], c));
      end
    end

    // R6 data memory window and R9 data-read register
    strm[1] = 17;
    for (int si = 0; si < 3; si++) begin
      wr(8'h00, 16'(strm[si]));
      for (int c = 0; c < 128; c++) begin
        rd_chk("R6 dmem read", 8'h80 | 8'(c), dm_word(12'(strm[si] * 128 + c)));
        if (c % 32 == 7)
          rd_chk("R9 data-read reg", 8'h02, dm_word(12'(strm[si] * 128 + c)));
      end
    end

    // R8 writes to read-only places
    wr(8'h00, 16'd5);
    ws = wr_strobes;
    wr(8'h85, 16'hFFFF);
    check("R8 dmem write no strobe", wr_strobes, ws);
    rd_chk("R8 dmem unchanged", 8'h85, dm_word(12'(5 * 128 + 5)));
    wr(8'h02, 16'hFFFF);
    check("R8 dread write no strobe", wr_strobes, ws);
    rd_chk("R8 dread unchanged", 8'h02, dm_word(12'(5 * 128 + 5)));

    // R10 memory select beyond the populated range
    for (int m = NCM + 1; m < 8; m++) begin
      wr(8'h00, 16'((m << 5) | 5));
      ws = wr_strobes;
      wr(8'h87, 16'h0F0F);
      check("R10 no strobe", wr_strobes, ws);
      rd_chk("R10 read zero", 8'h87, 16'h0000);
    end
    wr(8'h00, 16'((1 << 5) | 5));
    rd_chk("R10 cmem untouched", 8'h87, pat(1, 5, 7));

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule